// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Status Flags

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on the write clock and a consumer takes them on the read clock. The word width and the depth are parameters, and the depth must be a power of two. Words are held in a memory array. The write and read positions cross between the domains as Gray-coded counts through two-flop synchronisers.

A select pin fixes the read behaviour while master reset is high. In requested-read mode, every word is delivered only after a read strobe. In fall-through mode, the oldest word is moved into an output register on its own and shown with a valid indication. That register adds one word of capacity, so every fill threshold moves up by one word. Five flags report the fill state: an empty or output-ready flag, a full or input-ready flag, half-full, almost-empty and almost-full. The almost-empty and almost-full offsets are parameters.

Top module: `dual_mode_fifo`

## Requirements
- R1: `fwft_sel` is captured while `mrst` is high: 0 selects requested-read mode, 1 selects fall-through mode. Changing `fwft_sel` after reset has no effect until the next reset.
- R2: While `mrst` is high and after its release, the FIFO holds no words, `pae_n` = 0, `hf_n` = 1, `paf_n` = 1 and `dout` = 0.
- R3: In requested-read mode, a word leaves the FIFO only on a `rclk` edge with `ren_n` = 0, and it appears on `dout` after that edge. Without such a read, `dout` keeps its value. Words come out in the order they were written.
- R4: In fall-through mode, the oldest stored word appears on `dout` with `ef_or` = 0 without any read strobe. A `rclk` edge with `ren_n` = 0 consumes that word and brings up the next one. With `ren_n` = 1, `dout` holds.
- R5: The capacity is DEPTH words in requested-read mode and DEPTH+1 in fall-through mode. In requested-read mode `ff_ir` = 0 at capacity and 1 otherwise. In fall-through mode `ff_ir` = 1 at capacity and 0 otherwise. A write at capacity is dropped.
- R6: In requested-read mode `ef_or` = 1 exactly when words are stored. In fall-through mode `ef_or` = 0 exactly when a valid word is on `dout`. A read while empty changes neither `dout` nor the flags.
- R7: `pae_n` = 1 when more than AE_OFF words are stored in requested-read mode, or more than AE_OFF+1 in fall-through mode. Otherwise it is 0.
- R8: `hf_n` = 0 when at least DEPTH/2+1 words are stored in requested-read mode, or at least DEPTH/2+2 in fall-through mode. Otherwise it is 1.
- R9: `paf_n` = 0 when at least DEPTH-AF_OFF words are stored in requested-read mode, or at least DEPTH+1-AF_OFF in fall-through mode. Otherwise it is 1.
- R10: With both sides active at the same time on unrelated clocks, every accepted word is delivered exactly once and in write order. The FIFO ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| fwft_sel | input | 1 | Mode select, captured during reset (1 = fall-through) |
| wen_n | input | 1 | Write strobe, active low |
| din | input | DW | Write data |
| ren_n | input | 1 | Read strobe, active low |
| dout | output | DW | Read data |
| ef_or | output | 1 | Empty flag (requested-read mode) or output-ready flag (fall-through mode) |
| ff_ir | output | 1 | Full flag (requested-read mode) or input-ready flag (fall-through mode) |
| pae_n | output | 1 | Almost-empty, active low |
| hf_n | output | 1 | Half-full, active low |
| paf_n | output | 1 | Almost-full, active low |

## Verification
The bench builds the FIFO with DEPTH = 16, an almost-empty offset of 3 and an almost-full offset of 5. This lets it step one word at a time from empty to full and back in each mode. At every fill level it compares all five flags with thresholds computed from these numbers. It also covers the extra fall-through word, the dropped write at capacity and the ignored read at empty. A second phase runs the write side at 5 ns and the read side at 7.2 ns with irregular gaps on both sides. Ordering is checked against a queue while the full flag is hit repeatedly.

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW     = 9,
  parameter int DEPTH  = 256,
  parameter int AE_OFF = 7,
  parameter int AF_OFF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          fwft_sel,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  input  logic          ren_n,
  output logic [DW-1:0] dout,
  output logic          ef_or,
  output logic          ff_ir,
  output logic          pae_n,
  output logic          hf_n,
  output logic          paf_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int LW = AW + 2;

  localparam logic [LW-1:0] FULL_S = LW'(DEPTH);
  localparam logic [LW-1:0] FULL_F = LW'(DEPTH + 1);
  localparam logic [LW-1:0] HF_S   = LW'(DEPTH / 2 + 1);
  localparam logic [LW-1:0] HF_F   = LW'(DEPTH / 2 + 2);
  localparam logic [LW-1:0] AF_S   = LW'(DEPTH - AF_OFF);
  localparam logic [LW-1:0] AF_F   = LW'(DEPTH + 1 - AF_OFF);
  localparam logic [LW-1:0] AE_S   = LW'(AE_OFF);
  localparam logic [LW-1:0] AE_F   = LW'(AE_OFF + 1);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic          wmode, rmode;
  logic [PW-1:0] wptr, wgray;
  logic [PW-1:0] rptr, rgray;
  logic [PW-1:0] cptr, cgray;
  logic [PW-1:0] w2r_a, w2r_b;
  logic [PW-1:0] r2w_a, r2w_b;
  logic [PW-1:0] c2w_a, c2w_b;
  logic          ovalid;

  logic [PW-1:0] rbin_w, cbin_w, wbin_r;
  logic [LW-1:0] wlevel, wmem, rlevel;
  logic          wfull, wr_go, memne, pop, fetch, cinc;

  // write side
  assign rbin_w = g2b(r2w_b);
  assign cbin_w = g2b(c2w_b);
  assign wlevel = {1'b0, wptr - cbin_w};
  assign wmem   = {1'b0, wptr - rbin_w};
  assign wfull  = wmode ? (wlevel >= FULL_F || wmem >= FULL_S) : (wlevel >= FULL_S);
  assign wr_go  = !wen_n && !wfull;

  always_ff @(posedge wclk or posedge mrst) begin
    if (mrst) begin
      wmode <= fwft_sel;
      wptr  <= '0;
      wgray <= '0;
      r2w_a <= '0;
      r2w_b <= '0;
      c2w_a <= '0;
      c2w_b <= '0;
    end else begin
      r2w_a <= rgray;
      r2w_b <= r2w_a;
      c2w_a <= cgray;
      c2w_b <= c2w_a;
      if (wr_go) begin
        wptr  <= wptr + 1'b1;
        wgray <= b2g(wptr + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wptr[AW-1:0]] <= din;
  end

  // read side
  assign wbin_r = g2b(w2r_b);
  assign memne  = wbin_r != rptr;
  assign rlevel = {1'b0, wbin_r - cptr};
  assign pop    = rmode && ovalid && !ren_n;
  assign fetch  = memne && (rmode ? (!ovalid || pop) : !ren_n);
  assign cinc   = rmode ? pop : fetch;

  always_ff @(posedge rclk or posedge mrst) begin
    if (mrst) begin
      rmode  <= fwft_sel;
      rptr   <= '0;
      rgray  <= '0;
      cptr   <= '0;
      cgray  <= '0;
      w2r_a  <= '0;
      w2r_b  <= '0;
      ovalid <= 1'b0;
      dout   <= '0;
    end else begin
      w2r_a <= wgray;
      w2r_b <= w2r_a;
      if (fetch) begin
        dout  <= mem[rptr[AW-1:0]];
        rptr  <= rptr + 1'b1;
        rgray <= b2g(rptr + 1'b1);
      end
      if (rmode) ovalid <= fetch || (ovalid && !pop);
      if (cinc) begin
        cptr  <= cptr + 1'b1;
        cgray <= b2g(cptr + 1'b1);
      end
    end
  end

  // flags
  assign ef_or = rmode ? !ovalid : memne;
  assign ff_ir = wmode ? wfull : !wfull;
  assign pae_n = !(rlevel <= (rmode ? AE_F : AE_S));
  assign hf_n  = !(wlevel >= (wmode ? HF_F : HF_S));
  assign paf_n = !(wlevel >= (wmode ? AF_F : AF_S));

endmodule

// File: rtl/dual_mode_fifo_chk.sv
module dual_mode_fifo_chk #(
  parameter int DW = 9,
  parameter int PW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          wmode,
  input logic          rmode,
  input logic          wen_n,
  input logic          ren_n,
  input logic          ef_or,
  input logic          ff_ir,
  input logic          pae_n,
  input logic          hf_n,
  input logic          paf_n,
  input logic [DW-1:0] dout,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] wgray
);
  logic at_cap, no_words;
  assign at_cap   = wmode ? ff_ir : !ff_ir;
  assign no_words = rmode ? ef_or : !ef_or;

  AST_CAP_DROPS_WRITE: assert property (@(posedge wclk) disable iff (mrst) (at_cap && !wen_n) |=> $stable(wptr)); // R5
  AST_EMPTY_READ_INERT: assert property (@(posedge rclk) disable iff (mrst) (!rmode && !ef_or && !ren_n) |=> $stable(dout)); // R6
  AST_STD_OUT_HOLDS: assert property (@(posedge rclk) disable iff (mrst) (!rmode && ren_n) |=> $stable(dout)); // R3
  AST_FALL_OUT_HOLDS: assert property (@(posedge rclk) disable iff (mrst) (rmode && !ef_or && ren_n) |=> (!ef_or && $stable(dout))); // R4
  AST_CAP_MEANS_AF_HF: assert property (@(posedge wclk) disable iff (mrst) at_cap |-> (!paf_n && !hf_n)); // R9
  AST_EMPTY_MEANS_AE: assert property (@(posedge rclk) disable iff (mrst) no_words |-> !pae_n); // R7
  AST_GRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (mrst) $countones(wgray ^ $past(wgray)) <= 1); // R10
endmodule

bind dual_mode_fifo dual_mode_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .wmode(wmode), .rmode(rmode),
  .wen_n(wen_n), .ren_n(ren_n), .ef_or(ef_or), .ff_ir(ff_ir),
  .pae_n(pae_n), .hf_n(hf_n), .paf_n(paf_n), .dout(dout),
  .wptr(wptr), .wgray(wgray)
);

// File: tb/sim_dual_mode_fifo.sv
`timescale 1ns/1ps
module sim_dual_mode_fifo;
  localparam int DW = 9;
  localparam int D  = 16;
  localparam int AE = 3;
  localparam int AF = 5;
  localparam int NS = 150;

  logic wclk = 0, rclk = 0, mrst = 1, fwft_sel = 0, wen_n = 1, ren_n = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic ef_or, ff_ir, pae_n, hf_n, paf_n;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] q[$];

  always #2.5 wclk = ~wclk;
  always #3.6 rclk = ~rclk;

  dual_mode_fifo #(.DW(DW), .DEPTH(D), .AE_OFF(AE), .AF_OFF(AF)) u0 (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .fwft_sel(fwft_sel),
    .wen_n(wen_n), .din(din), .ren_n(ren_n), .dout(dout),
    .ef_or(ef_or), .ff_ir(ff_ir), .pae_n(pae_n), .hf_n(hf_n), .paf_n(paf_n)
  );

  task automatic eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (6) @(posedge wclk);
    #1;
  endtask

  task automatic do_reset(input int md);
    @(negedge rclk);
    mrst = 1; fwft_sel = md[0]; wen_n = 1; ren_n = 1;
    repeat (3) @(negedge rclk);
    mrst = 0;
    @(negedge rclk);
    fwft_sel = ~md[0];
    q.delete();
  endtask

  task automatic write_word(input logic [DW-1:0] d);
    @(negedge wclk); wen_n = 0; din = d;
    @(negedge wclk); wen_n = 1;
  endtask

  task automatic read_pulse();
    @(negedge rclk); ren_n = 0;
    @(negedge rclk); ren_n = 1;
  endtask

  task automatic check_flags(input int md, input int cnt);
    eq("R6", "empty/ready flag", ef_or, md ? int'(cnt == 0) : int'(cnt != 0));
    eq("R5", "full/ready flag", ff_ir, md ? int'(cnt >= D + 1) : int'(cnt < D));
    eq("R7", "almost-empty", pae_n, int'(cnt > AE + md));
    eq("R8", "half-full", hf_n, int'(cnt < D / 2 + 1 + md));
    eq("R9", "almost-full", paf_n, int'(cnt < D - AF + md));
  endtask

  task automatic sweep(input int md);
    int cnt;
    logic [DW-1:0] last, w;
    cnt = 0;
    do_reset(md);
    settle();
    eq("R1", "empty/ready after pin flip", ef_or, md);
    eq("R1", "full/ready after pin flip", ff_ir, md ? 0 : 1);
    eq("R2", "reset almost-empty", pae_n, 0);
    eq("R2", "reset half-full", hf_n, 1);
    eq("R2", "reset almost-full", paf_n, 1);
    eq("R2", "reset dout", dout, 0);
    for (int i = 0; i < D + md; i++) begin
      w = DW'((i * 37 + 5) & 255);
      write_word(w);
      q.push_back(w);
      cnt++;
      settle();
      check_flags(md, cnt);
      if (md != 0) eq("R4", "head word without read", dout, q[0]);
      else if (i == 0) eq("R3", "dout held without read", dout, 0);
    end
    write_word(9'h155);
    settle();
    check_flags(md, cnt);
    while (cnt > 0) begin
      if (md != 0) begin
        eq("R4", "head before pop", dout, q[0]);
        read_pulse();
        void'(q.pop_front());
      end else begin
        read_pulse();
        eq("R3", "requested word", dout, q.pop_front());
      end
      cnt--;
      settle();
      check_flags(md, cnt);
    end
    last = dout;
    read_pulse();
    settle();
    eq("R6", "read at empty leaves dout", dout, last);
    check_flags(md, 0);
  endtask

  task automatic stream(input int md);
    do_reset(md);
    settle();
    fork
      begin
        int i, cyc;
        i = 0; cyc = 0;
        while (i < NS) begin
          @(negedge wclk);
          cyc++;
          if ((md != 0 ? !ff_ir : ff_ir) && (cyc % 7 != 6)) begin
            wen_n = 0;
            din = DW'((i * 53 + 11) % 512);
            q.push_back(din);
            i++;
          end else wen_n = 1;
        end
        @(negedge wclk); wen_n = 1;
      end
      begin
        int j, cyc;
        bit pend;
        j = 0; cyc = 0; pend = 0;
        while (j < NS) begin
          @(negedge rclk);
          cyc++;
          if (md != 0) begin
            if (!ef_or && (cyc % 5 != 3)) begin
              eq("R10", "streamed word", dout, q.pop_front());
              ren_n = 0; j++;
            end else ren_n = 1;
          end else begin
            if (pend) begin
              eq("R10", "streamed word", dout, q.pop_front());
              pend = 0;
            end
            if (ef_or && (cyc % 5 != 3)) begin
              ren_n = 0; pend = 1; j++;
            end else ren_n = 1;
          end
        end
        @(negedge rclk); ren_n = 1;
        if (pend) eq("R10", "streamed word", dout, q.pop_front());
      end
    join
    settle();
    eq("R10", "queue drained", q.size(), 0);
    check_flags(md, 0);
  endtask

  initial begin
    repeat (2) @(negedge rclk);
    for (int md = 0; md < 2; md++) sweep(md);
    for (int md = 0; md < 2; md++) stream(md);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule